// File: doc/BRIEF.md
# Sequential signed multiply/divide unit with HI/LO result registers

This block performs signed two's-complement multiplication and division over several clock cycles and keeps the outcome in two dedicated result registers, HI and LO. A request is made by pulsing `start` with two operands and a 6-bit function code. Code 0x18 selects multiply and code 0x1A selects divide. Multiply uses a shift-add loop and divide uses a restoring loop, and each loop advances one bit per cycle.

`busy` stays high while an operation is in flight. `done` pulses for one cycle when the new HI/LO values become visible. Both registers are always readable on `hi_out` and `lo_out`, as a move-from-HI or move-from-LO instruction would need. If a move-from read is requested through `rd_req` while the unit is busy, `stall` is raised so that a pipeline can hold the reading instruction.

A multiply puts the full double-width product across the two registers: the upper half goes to HI and the lower half to LO. A divide puts the quotient in LO and the remainder in HI.

Top module: `hilo_muldiv`

## Requirements
- R1: With function code 0x18, the signed product of `op_a` and `op_b` is written with its low W bits in LO and its high W bits in HI.
- R2: With function code 0x1A and a nonzero divisor, LO receives the signed quotient truncated toward zero and HI the remainder, which carries the sign of the dividend.
- R3: A divide whose divisor is zero still completes, with LO all ones and HI equal to the dividend.
- R4: A `start` pulse carrying any function code other than 0x18 or 0x1A is ignored: `busy` stays low and HI/LO keep their values.
- R5: A `start` pulse while `busy` is high is ignored, and the running operation finishes with its own operands.
- R6: After an accepted `start`, `busy` is high for exactly W+1 cycles. `done` is high for exactly one cycle, which is the first cycle with `busy` low.
- R7: HI and LO change only together, in the cycle `done` is high. Reads made while busy return the previous results.
- R8: `stall` is high exactly when `rd_req` is high while `busy` is high, and it is never high while the unit is idle.
- R9: After synchronous reset, `busy`, `done` and `stall` are low and HI and LO are zero.
- R10: Dividing the most negative value by -1 gives LO equal to the most negative value and HI zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled while idle |
| funct | input | 6 | Operation code: 0x18 multiply, 0x1A divide |
| op_a | input | W | Multiplicand or dividend (signed) |
| op_b | input | W | Multiplier or divisor (signed) |
| rd_req | input | 1 | A move-from-HI/LO read is being attempted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| stall | output | 1 | Hold request for a read made while busy |
| hi_out | output | W | HI register contents |
| lo_out | output | W | LO register contents |

## Verification
On every cycle, the assertions check the timing contract: the length of the busy window, the single-cycle `done` pulse, that HI/LO never move outside that pulse, and that `stall` follows busy reads. The arithmetic can only be shown by scenarios. The bench sweeps every operand pair of a 6-bit configuration through both operations, which covers the zero-divisor rule, the most-negative-by-minus-one case and sign handling. The bench also injects ignored requests and busy-time reads during those runs.

// File: rtl/hilo_muldiv_pkg.sv
package hilo_muldiv_pkg;

    localparam logic [5:0] FN_MULT = 6'h18;
    localparam logic [5:0] FN_DIV  = 6'h1A;

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_DIV = 1'b1
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } md_state_e;

    typedef struct packed {
        md_op_e op;
        logic   neg_main;   // negate product or quotient
        logic   neg_rem;    // negate remainder
        logic   div_zero;   // divisor was zero
    } md_req_t;

    function automatic logic fn_known(input logic [5:0] fn);
        return (fn == FN_MULT) || (fn == FN_DIV);
    endfunction

    function automatic md_op_e fn_to_op(input logic [5:0] fn);
        return (fn == FN_DIV) ? OP_DIV : OP_MUL;
    endfunction

endpackage

// File: rtl/hilo_md_ctrl.sv
module hilo_md_ctrl
    import hilo_muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic accept_req,
    output logic load,
    output logic step,
    output logic finish,
    output logic busy
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    md_state_e      state_q;
    logic [CW-1:0]  cnt_q;

    assign load   = accept_req && (state_q == ST_IDLE);
    assign step   = (state_q == ST_RUN);
    assign finish = (state_q == ST_FIX);
    assign busy   = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (accept_req) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_FIX;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hilo_mul_core.sv
module hilo_mul_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    output logic [2*W-1:0] prod
);
    logic [W-1:0] hi_q, lo_q, mcand_q;
    logic [W:0]   sum;

    // one shift-add iteration: add multiplicand if the current multiplier bit is set
    assign sum  = {1'b0, hi_q} + (lo_q[0] ? {1'b0, mcand_q} : '0);
    assign prod = {hi_q, lo_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            lo_q    <= '0;
            mcand_q <= '0;
        end else if (load) begin
            hi_q    <= '0;
            lo_q    <= mag_a;
            mcand_q <= mag_b;
        end else if (step) begin
            hi_q <= sum[W:1];
            lo_q <= {sum[0], lo_q[W-1:1]};
        end
    end
endmodule

// File: rtl/hilo_div_core.sv
module hilo_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    logic [W-1:0] rem_q, quo_q, dvs_q;
    logic [W:0]   trial, diff;
    logic         fits;

    // restoring step: shift in next dividend bit, subtract if it fits
    assign trial = {rem_q, quo_q[W-1]};
    assign diff  = trial - {1'b0, dvs_q};
    assign fits  = (trial >= {1'b0, dvs_q});
    assign quo   = quo_q;
    assign rem   = rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= mag_a;
            dvs_q <= mag_b;
        end else if (step) begin
            rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
            quo_q <= {quo_q[W-2:0], fits};
        end
    end
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import hilo_muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [5:0]   funct,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         rd_req,
    output logic         busy,
    output logic         done,
    output logic         stall,
    output logic [W-1:0] hi_out,
    output logic [W-1:0] lo_out
);
    localparam int PW = 2 * W;

    logic           load, step, finish, busy_i;
    logic           accept_req;
    logic [W-1:0]   mag_a, mag_b;
    logic [PW-1:0]  prod;
    logic [W-1:0]   quo, rem;
    md_req_t        req_q, req_d;
    logic [W-1:0]   dividend_q;
    logic [W-1:0]   hi_q, lo_q;
    logic           done_q;
    logic [PW-1:0]  prod_fix;
    logic [W-1:0]   quo_fix, rem_fix;
    logic           mul_en, div_en;

    assign accept_req = start && fn_known(funct);

    assign mag_a = op_a[W-1] ? (~op_a + 1'b1) : op_a;
    assign mag_b = op_b[W-1] ? (~op_b + 1'b1) : op_b;

    always_comb begin
        req_d.op       = fn_to_op(funct);
        req_d.div_zero = (op_b == '0);
        req_d.neg_rem  = op_a[W-1];
        req_d.neg_main = op_a[W-1] ^ op_b[W-1];
    end

    hilo_md_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .accept_req (accept_req),
        .load       (load),
        .step       (step),
        .finish     (finish),
        .busy       (busy_i)
    );

    assign mul_en = (req_q.op == OP_MUL);
    assign div_en = (req_q.op == OP_DIV);

    hilo_mul_core #(.W(W)) u_mul (
        .clk   (clk),
        .rst   (rst),
        .load  (load && (req_d.op == OP_MUL)),
        .step  (step && mul_en),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .prod  (prod)
    );

    hilo_div_core #(.W(W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .load  (load && (req_d.op == OP_DIV)),
        .step  (step && div_en),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .quo   (quo),
        .rem   (rem)
    );

    assign prod_fix = req_q.neg_main ? (~prod + 1'b1) : prod;
    assign quo_fix  = req_q.neg_main ? (~quo + 1'b1) : quo;
    assign rem_fix  = req_q.neg_rem  ? (~rem + 1'b1) : rem;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q      <= '0;
            dividend_q <= '0;
            hi_q       <= '0;
            lo_q       <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= finish;
            if (load) begin
                req_q      <= req_d;
                dividend_q <= op_a;
            end
            if (finish) begin
                if (req_q.op == OP_MUL) begin
                    hi_q <= prod_fix[PW-1:W];
                    lo_q <= prod_fix[W-1:0];
                end else if (req_q.div_zero) begin
                    hi_q <= dividend_q;
                    lo_q <= '1;
                end else begin
                    hi_q <= rem_fix;
                    lo_q <= quo_fix;
                end
            end
        end
    end

    assign busy   = busy_i;
    assign done   = done_q;
    assign stall  = rd_req && busy_i;
    assign hi_out = hi_q;
    assign lo_out = lo_q;
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         stall,
    input logic         rd_req,
    input logic [W-1:0] hi_out,
    input logic [W-1:0] lo_out
);
    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) busy_cnt <= 0;
        else     busy_cnt <= busy ? busy_cnt + 1 : 0;
    end

    assert_busy_len_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == W + 1));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_from_start_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    assert_hilo_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(hi_out) && $stable(lo_out)));

    assert_no_idle_stall_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !stall);

    assert_busy_read_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && rd_req) |-> stall);
endmodule

bind hilo_muldiv hilo_muldiv_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .stall  (stall),
    .rd_req (rd_req),
    .hi_out (hi_out),
    .lo_out (lo_out)
);

// File: tb/sim_hilo_muldiv.sv
module sim_hilo_muldiv;
    localparam int W = 6;
    localparam int N = 1 << W;
    localparam logic [W-1:0] MASK = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [5:0]   funct = 6'h00;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic         rd_req = 1'b0;
    logic         busy, done, stall;
    logic [W-1:0] hi_out, lo_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    hilo_muldiv #(.W(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .funct(funct),
        .op_a(op_a), .op_b(op_b), .rd_req(rd_req),
        .busy(busy), .done(done), .stall(stall),
        .hi_out(hi_out), .lo_out(lo_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic longint sval(input logic [W-1:0] v);
        return v[W-1] ? longint'(v) - N : longint'(v);
    endfunction

    task automatic run_op(input logic [5:0] fn, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] old_hi, old_lo, exp_hi, exp_lo;
        longint sa, sb, p, q, r;
        int cnt;
        string tag;
        old_hi = hi_out;
        old_lo = lo_out;
        sa = sval(a);
        sb = sval(b);
        if (fn == 6'h18) begin
            p = sa * sb;
            exp_lo = W'(p);
            exp_hi = W'(p >>> W);
            tag = "R1";
        end else if (b == '0) begin
            exp_lo = MASK;
            exp_hi = a;
            tag = "R3";
        end else begin
            q = sa / sb;
            r = sa % sb;
            exp_lo = W'(q);
            exp_hi = W'(r);
            tag = (sa == -(N / 2) && sb == -1) ? "R10" : "R2";
        end
        @(negedge clk);
        funct = fn; op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (busy && cnt < 4 * W) begin
            cnt++;
            if (cnt == 1) begin
                rd_req = 1'b1;
                #0;
                check(stall === 1'b1, "R8", stall, 1);
                check(hi_out === old_hi && lo_out === old_lo, "R7", hi_out, old_hi);
            end
            if (cnt == 2) begin
                rd_req = 1'b0;
                start = 1'b1; funct = 6'h18; op_a = ~a; op_b = ~b;
            end
            if (cnt == 3) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        rd_req = 1'b1;
        #0;
        check(cnt == W + 1, "R6", cnt, W + 1);
        check(done === 1'b1, "R6", done, 1);
        check(stall === 1'b0, "R8", stall, 0);
        check(lo_out === exp_lo, {tag, "/R5 LO"}, lo_out, exp_lo);
        check(hi_out === exp_hi, {tag, "/R5 HI"}, hi_out, exp_hi);
        @(negedge clk);
        rd_req = 1'b0;
        check(done === 1'b0 && busy === 1'b0, "R6", {done, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && stall === 1'b0, "R9", {busy, done, stall}, 0);
        check(hi_out === '0 && lo_out === '0, "R9", {hi_out, lo_out}, 0);
        rst = 1'b0;
        @(negedge clk);

        // ignored function codes must not start anything
        run_op(6'h18, 6'd5, 6'd7);
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] h0, l0;
            h0 = hi_out; l0 = lo_out;
            @(negedge clk);
            funct = (k == 0) ? 6'h00 : (k == 1) ? 6'h19 : (k == 2) ? 6'h1B : 6'h3F;
            op_a = 6'd9; op_b = 6'd3; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy === 1'b0, "R4 busy", busy, 0);
            repeat (W + 3) @(negedge clk);
            check(hi_out === h0 && lo_out === l0 && done === 1'b0, "R4 hold", {hi_out, lo_out}, {h0, l0});
        end

        for (int op = 0; op < 2; op++) begin
            for (int a = 0; a < N; a++) begin
                for (int b = 0; b < N; b++) begin
                    run_op(op == 0 ? 6'h18 : 6'h1A, W'(a), W'(b));
                end
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule